// File: doc/BRIEF.md
# Double-Data-Rate Prefetch Gearbox

This block joins a memory core that moves one 2n-bit word per core clock to a pin interface that moves one n-bit word per half clock. It is split into byte lanes, and every lane has its own strobe. On the read side the block takes one core word per core cycle. It drives the lower half onto the pins during the first half-cycle and the upper half during the second. A strobe goes out with the data. Its edges fall on the data transitions, and it is framed by a low preamble and a low postamble. On the write side each lane watches its own incoming strobe. A rising strobe edge captures the lower half-word and a falling edge captures the upper half-word. The block then delivers the completed word to the core.

Half-cycle timing is modelled with a clock running at twice the core rate, so the logic needs no dual-edge primitives. An internal phase register marks which half of the core cycle the next fast edge begins. It is visible on `half_sel`. Write data is sampled on the fast clock together with the strobe level. The source keeps the data stable across each strobe edge, which is the center-aligned arrangement, so data sampled with a detected edge is valid. A write-burst flag gates capture, and dropping it discards any word that is only half captured.

Top module: `ddr_gearbox`

## Requirements
- R1: After reset, every `dq_oe`, `dqs_oe` and `wr_valid` bit is 0 and `half_sel` is 0.
- R2: A read word accepted at an edge where `half_sel` was 0 appears on `dq_out` with bits [n-1:0] in the first fast cycle of its data slot and bits [2n-1:n] in the second.
- R3: While read data is driven, each lane strobe is 1 during the lower-half cycle and 0 during the upper-half cycle, so it toggles on every data transition.
- R4: Exactly one fast cycle before a lane first drives read data, its strobe is driven (`dqs_oe`=1) with value 0 while `dq_oe` is 0 (preamble).
- R5: Exactly one fast cycle after the last read half-word, the strobe stays driven at 0 with `dq_oe` 0 (postamble). In the cycle after that it is released.
- R6: With no read burst in flight, `dq_oe` and `dqs_oe` are 0, and `dq_oe` is never 1 while `dqs_oe` is 0.
- R7: With `wr_active` high, a lane that sees its strobe rise and then fall captures the data sampled at the rise into the low byte of its slot in `wr_word` and the data sampled at the fall into the high-half byte. It raises `wr_valid` for exactly one fast cycle, in the cycle after the fall is sampled. The lower half of `wr_word` is [n-1:0], and lane l owns bits [8l+7:8l] and [n+8l+7:n+8l].
- R8: Each lane captures only on its own strobe. A lane whose strobe stays low raises no `wr_valid` and does not change its bytes.
- R9: While `wr_active` is 0, strobe edges are ignored and `wr_valid` stays 0. A half-captured word is discarded when `wr_active` drops, even if the matching falling edge follows after it returns.
- R10: `half_sel` alternates on every fast clock edge. The read data slot starts two fast edges after the accepting edge.
- R11: Read words accepted at consecutive even edges stream out without a gap, and no preamble or postamble is inserted between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the core rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_sel | output | 1 | 0 when the next edge starts a core cycle (read accept edge) |
| rd_valid | input | 1 | Read word present, sampled when `half_sel` is 0 |
| rd_word | input | 2*DQ_W | Core read word, lower half sent first |
| dq_out | output | DQ_W | Pin data out |
| dq_oe | output | DQ_W/LANE_W | Per-lane data output enable |
| dqs_out | output | DQ_W/LANE_W | Per-lane strobe out |
| dqs_oe | output | DQ_W/LANE_W | Per-lane strobe output enable |
| wr_active | input | 1 | Write burst in progress, gates capture |
| dq_in | input | DQ_W | Pin data in |
| dqs_in | input | DQ_W/LANE_W | Per-lane incoming strobe |
| wr_word | output | 2*DQ_W | Captured core write word |
| wr_valid | output | DQ_W/LANE_W | Per-lane one-cycle word-complete pulse |

## Verification
Some rules are checked on every cycle. The outgoing strobe must toggle on every data half, and must rise with the first half. The strobe must be driven whenever data is driven. Data can start only after a low preamble cycle and can stop only into a low postamble cycle. The phase alternates each edge, write valids are single-cycle pulses, and no valid follows an inactive write flag. Other behaviour only the bench's scenarios can show: which half-word lands in which pin cycle and which byte slot, the exact latency from accept to pins, gapless streaming, lane independence, and discarding of a half-captured word.

// File: rtl/ddrgb_pkg.sv
package ddrgb_pkg;
   typedef enum logic {SLOT_EVEN = 1'b0, SLOT_ODD = 1'b1} slot_e;
endpackage

// File: rtl/ddrgb_phase.sv
module ddrgb_phase
   import ddrgb_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   output slot_e slot
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot <= SLOT_EVEN;
      else        slot <= (slot == SLOT_EVEN) ? SLOT_ODD : SLOT_EVEN;
   end
endmodule

// File: rtl/ddrgb_rd_lane.sv
module ddrgb_rd_lane
   import ddrgb_pkg::*;
#(
   parameter int W = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  slot_e        slot,
   input  logic         load_v,
   input  logic [W-1:0] load_lo,
   input  logic [W-1:0] load_hi,
   output logic [W-1:0] dq,
   output logic         dq_oe,
   output logic         dqs,
   output logic         dqs_oe
);
   logic         stage_v, out_v;
   logic [W-1:0] stage_lo, stage_hi, out_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_v  <= 1'b0;
         stage_lo <= '0;
         stage_hi <= '0;
         out_v    <= 1'b0;
         out_hi   <= '0;
         dq       <= '0;
         dq_oe    <= 1'b0;
         dqs      <= 1'b0;
         dqs_oe   <= 1'b0;
      end else if (slot == SLOT_EVEN) begin
         stage_v  <= load_v;
         stage_lo <= load_lo;
         stage_hi <= load_hi;
         out_v    <= stage_v;
         out_hi   <= stage_hi;
         dq       <= stage_v ? stage_lo : '0;
         dq_oe    <= stage_v;
         dqs      <= stage_v;
         dqs_oe   <= stage_v | out_v;
      end else begin
         dq       <= out_v ? out_hi : '0;
         dq_oe    <= out_v;
         dqs      <= 1'b0;
         dqs_oe   <= out_v | stage_v;
      end
   end
endmodule

// File: rtl/ddrgb_wr_lane.sv
module ddrgb_wr_lane #(
   parameter int W = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic         dqs,
   input  logic [W-1:0] dq,
   output logic [W-1:0] word_lo,
   output logic [W-1:0] word_hi,
   output logic         valid
);
   logic         prev, half;
   logic [W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev    <= 1'b0;
         half    <= 1'b0;
         lo_q    <= '0;
         word_lo <= '0;
         word_hi <= '0;
         valid   <= 1'b0;
      end else begin
         prev  <= dqs;
         valid <= 1'b0;
         if (!active) begin
            half <= 1'b0;
         end else if (dqs && !prev) begin
            lo_q <= dq;
            half <= 1'b1;
         end else if (!dqs && prev && half) begin
            word_lo <= lo_q;
            word_hi <= dq;
            valid   <= 1'b1;
            half    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ddr_gearbox.sv
module ddr_gearbox
   import ddrgb_pkg::*;
#(
   parameter int DQ_W   = 16,
   parameter int LANE_W = 8
)(
   input  logic                        clk,
   input  logic                        rst_n,
   output logic                        half_sel,
   input  logic                        rd_valid,
   input  logic [2*DQ_W-1:0]           rd_word,
   output logic [DQ_W-1:0]             dq_out,
   output logic [DQ_W/LANE_W-1:0]      dq_oe,
   output logic [DQ_W/LANE_W-1:0]      dqs_out,
   output logic [DQ_W/LANE_W-1:0]      dqs_oe,
   input  logic                        wr_active,
   input  logic [DQ_W-1:0]             dq_in,
   input  logic [DQ_W/LANE_W-1:0]      dqs_in,
   output logic [2*DQ_W-1:0]           wr_word,
   output logic [DQ_W/LANE_W-1:0]      wr_valid
);
   localparam int LANES = DQ_W / LANE_W;

   if (LANE_W < 1) begin : g_bad_lane
      $error("ddr_gearbox: LANE_W must be positive");
   end
   if (DQ_W % LANE_W != 0) begin : g_bad_split
      $error("ddr_gearbox: DQ_W must be a multiple of LANE_W");
   end

   slot_e slot;

   ddrgb_phase u_phase (.clk(clk), .rst_n(rst_n), .slot(slot));

   assign half_sel = (slot == SLOT_ODD);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      ddrgb_rd_lane #(.W(LANE_W)) u_rd (
         .clk     (clk),
         .rst_n   (rst_n),
         .slot    (slot),
         .load_v  (rd_valid),
         .load_lo (rd_word[l*LANE_W +: LANE_W]),
         .load_hi (rd_word[DQ_W + l*LANE_W +: LANE_W]),
         .dq      (dq_out[l*LANE_W +: LANE_W]),
         .dq_oe   (dq_oe[l]),
         .dqs     (dqs_out[l]),
         .dqs_oe  (dqs_oe[l])
      );

      ddrgb_wr_lane #(.W(LANE_W)) u_wr (
         .clk     (clk),
         .rst_n   (rst_n),
         .active  (wr_active),
         .dqs     (dqs_in[l]),
         .dq      (dq_in[l*LANE_W +: LANE_W]),
         .word_lo (wr_word[l*LANE_W +: LANE_W]),
         .word_hi (wr_word[DQ_W + l*LANE_W +: LANE_W]),
         .valid   (wr_valid[l])
      );
   end
endmodule

// File: rtl/ddrgb_chk.sv
module ddrgb_chk #(
   parameter int LANES = 2
)(
   input logic             clk,
   input logic             rst_n,
   input logic             half_sel,
   input logic [LANES-1:0] dq_oe,
   input logic [LANES-1:0] dqs_out,
   input logic [LANES-1:0] dqs_oe,
   input logic             wr_active,
   input logic [LANES-1:0] wr_valid
);
   logic pv;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pv <= 1'b0;
      else        pv <= 1'b1;
   end

   a_r10_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
      pv |-> half_sel != $past(half_sel));

   for (genvar l = 0; l < LANES; l++) begin : g_l
      a_r3_strobe_toggles: assert property (@(posedge clk) disable iff (!rst_n)
         pv && dq_oe[l] && $past(dq_oe[l]) |-> dqs_out[l] != $past(dqs_out[l]));
      a_r3_first_half_high: assert property (@(posedge clk) disable iff (!rst_n)
         pv && $rose(dq_oe[l]) |-> dqs_out[l]);
      a_r4_preamble: assert property (@(posedge clk) disable iff (!rst_n)
         pv && $rose(dq_oe[l]) |-> $past(dqs_oe[l]) && !$past(dqs_out[l]));
      a_r5_postamble: assert property (@(posedge clk) disable iff (!rst_n)
         pv && $fell(dq_oe[l]) |-> dqs_oe[l] && !dqs_out[l]);
      a_r6_data_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
         dq_oe[l] |-> dqs_oe[l]);
      a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         wr_valid[l] |=> !wr_valid[l]);
      a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_active |=> !wr_valid[l]);
   end
endmodule

bind ddr_gearbox ddrgb_chk #(.LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .half_sel  (half_sel),
   .dq_oe     (dq_oe),
   .dqs_out   (dqs_out),
   .dqs_oe    (dqs_oe),
   .wr_active (wr_active),
   .wr_valid  (wr_valid)
);

// File: tb/sim_ddr_gearbox.sv
module sim_ddr_gearbox;
   localparam int CLK_PERIOD = 10;
   localparam int N = 16;
   localparam int L = 2;
   localparam logic [L-1:0] ALL = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic half_sel;
   logic rd_valid = 1'b0;
   logic [2*N-1:0] rd_word = '0;
   logic [N-1:0] dq_out;
   logic [L-1:0] dq_oe, dqs_out, dqs_oe;
   logic wr_active = 1'b0;
   logic [N-1:0] dq_in = '0;
   logic [L-1:0] dqs_in = '0;
   logic [2*N-1:0] wr_word;
   logic [L-1:0] wr_valid;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ddr_gearbox #(.DQ_W(N), .LANE_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .half_sel(half_sel),
      .rd_valid(rd_valid), .rd_word(rd_word),
      .dq_out(dq_out), .dq_oe(dq_oe), .dqs_out(dqs_out), .dqs_oe(dqs_oe),
      .wr_active(wr_active), .dq_in(dq_in), .dqs_in(dqs_in),
      .wr_word(wr_word), .wr_valid(wr_valid)
   );

   task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [2*N-1:0] mkword(input int i, input int seed);
      return (32'(seed) * 32'h9E37_79B9) ^ (32'(i) * 32'h0103_0507 + 32'h1234_5678);
   endfunction

   task automatic read_burst(input int nw, input int seed);
      while (half_sel !== 1'b0) @(negedge clk);
      fork
         begin
            for (int i = 0; i < nw; i++) begin
               rd_valid = 1'b1;
               rd_word  = mkword(i, seed);
               @(negedge clk);
               @(negedge clk);
            end
            rd_valid = 1'b0;
         end
         begin
            for (int t = 0; t <= 3 + 2*nw; t++) begin
               @(negedge clk);
               if (t == 1) begin
                  check_eq("R4 preamble dqs_oe", 64'(dqs_oe), 64'(ALL));
                  check_eq("R4 preamble dqs", 64'(dqs_out), 64'(0));
                  check_eq("R4 preamble dq_oe", 64'(dq_oe), 64'(0));
               end else if (t >= 2 && t < 2 + 2*nw) begin
                  logic [2*N-1:0] w;
                  w = mkword((t-2)/2, seed);
                  check_eq("R10 R11 data dq_oe", 64'(dq_oe), 64'(ALL));
                  check_eq("R6 data dqs_oe", 64'(dqs_oe), 64'(ALL));
                  if (t % 2 == 0) begin
                     check_eq("R2 lower half first", 64'(dq_out), 64'(w[N-1:0]));
                     check_eq("R3 strobe high", 64'(dqs_out), 64'(ALL));
                  end else begin
                     check_eq("R2 upper half second", 64'(dq_out), 64'(w[2*N-1:N]));
                     check_eq("R3 strobe low", 64'(dqs_out), 64'(0));
                  end
               end else if (t == 2 + 2*nw) begin
                  check_eq("R5 postamble dqs_oe", 64'(dqs_oe), 64'(ALL));
                  check_eq("R5 postamble dqs", 64'(dqs_out), 64'(0));
                  check_eq("R5 postamble dq_oe", 64'(dq_oe), 64'(0));
               end else if (t == 3 + 2*nw) begin
                  check_eq("R5 R6 released dqs_oe", 64'(dqs_oe), 64'(0));
                  check_eq("R6 released dq_oe", 64'(dq_oe), 64'(0));
               end
            end
         end
      join
   endtask

   task automatic write_burst(input int nw, input logic [L-1:0] mask, input int seed);
      @(negedge clk);
      wr_active = 1'b1;
      dqs_in    = '0;
      @(negedge clk);
      for (int i = 0; i < nw; i++) begin
         logic [2*N-1:0] w;
         w = mkword(i, seed);
         dq_in  = w[N-1:0];
         dqs_in = mask;
         @(negedge clk);
         check_eq("R7 no valid mid word", 64'(wr_valid), 64'(0));
         dq_in  = w[2*N-1:N];
         dqs_in = '0;
         @(negedge clk);
         check_eq("R7 R8 valid lanes", 64'(wr_valid), 64'(mask));
         for (int l = 0; l < L; l++) begin
            if (mask[l]) begin
               check_eq("R7 low byte slot", 64'(wr_word[l*8 +: 8]), 64'(w[l*8 +: 8]));
               check_eq("R7 high byte slot", 64'(wr_word[N + l*8 +: 8]), 64'(w[N + l*8 +: 8]));
            end
         end
      end
      wr_active = 1'b0;
      @(negedge clk);
      check_eq("R7 valid single cycle", 64'(wr_valid), 64'(0));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [2*N-1:0] keep;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_eq("R1 reset dq_oe", 64'(dq_oe), 64'(0));
      check_eq("R1 reset dqs_oe", 64'(dqs_oe), 64'(0));
      check_eq("R1 reset wr_valid", 64'(wr_valid), 64'(0));
      check_eq("R1 reset half_sel", 64'(half_sel), 64'(0));
      @(negedge clk);
      check_eq("R10 phase toggles", 64'(half_sel), 64'(1));
      @(negedge clk);
      check_eq("R10 phase toggles back", 64'(half_sel), 64'(0));

      for (int nw = 1; nw <= 4; nw++) begin
         read_burst(nw, nw * 7);
         repeat (3) @(negedge clk);
      end

      for (int m = 1; m <= 3; m++) begin
         for (int nw = 1; nw <= 3; nw++) begin
            write_burst(nw, m[L-1:0], m * 11 + nw);
         end
      end

      // R8: lane 0 idle while lane 1 captures keeps lane 0 bytes
      keep = wr_word;
      write_burst(2, 2'b10, 99);
      check_eq("R8 idle lane bytes kept lo", 64'(wr_word[7:0]), 64'(keep[7:0]));
      check_eq("R8 idle lane bytes kept hi", 64'(wr_word[N+7:N]), 64'(keep[N+7:N]));

      // R9: edges with wr_active low are ignored
      @(negedge clk);
      wr_active = 1'b0;
      dq_in = 16'hA5A5;
      dqs_in = ALL;
      @(negedge clk);
      check_eq("R9 inactive rise ignored", 64'(wr_valid), 64'(0));
      dq_in = 16'h5A5A;
      dqs_in = '0;
      @(negedge clk);
      check_eq("R9 inactive fall ignored", 64'(wr_valid), 64'(0));

      // R9: half-captured word discarded when active drops
      wr_active = 1'b1;
      dq_in = 16'h1111;
      dqs_in = ALL;
      @(negedge clk);
      wr_active = 1'b0;
      @(negedge clk);
      wr_active = 1'b1;
      @(negedge clk);
      dq_in = 16'h2222;
      dqs_in = '0;
      @(negedge clk);
      check_eq("R9 half word discarded", 64'(wr_valid), 64'(0));
      wr_active = 1'b0;
      write_burst(1, ALL, 5);

      // R11 again with a longer gapless stream
      repeat (2) @(negedge clk);
      read_burst(6, 3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule